// File: doc/BRIEF.md
# Serial Audio Port FIFO and Control Unit

This block sits between a 32-bit register bus and the bit-level engine of a serial audio port. Software, or a DMA engine, fills a transmit sample FIFO and empties a receive sample FIFO through one shared data address. The block also holds the port configuration, the run controls and the clock divider settings that the serial engine consumes. Two FIFO thresholds decide when DMA requests and service interrupts are raised. Underrun and overrun are kept as sticky status bits.

The serial engine pulls transmit samples through a valid/ready pair. `tx_valid` is high while playback runs. A sample moves on every cycle where `tx_valid` and `tx_ready` are both high. If the FIFO is empty at that moment, the handshake still completes with a fill value and an underrun is recorded. The engine pushes capture samples with `rx_valid`, and `rx_ready` is low while the receive FIFO is full. A push offered while capture runs and `rx_ready` is low is an overrun: the sample is dropped, the FIFO is left unchanged, and a sticky bit is set.

Bus accesses complete in one cycle. Read data is combinational from the current state. Register writes and FIFO pushes or pops take effect at the clock edge of the access. Each DMA burst moves at most 16 words. The default thresholds leave room for such a burst in a 32-entry FIFO.

Top module: `aud_fifo_ctrl`

## Requirements
- R1: After reset, the configuration register (byte offset 0x00) reads 0x0000_7800: receive threshold 7 in bits 15:12, transmit threshold 8 in bits 11:8, all other bits zero. Control, divider and FIFO status read zero, and `tx_valid`, `rx_ready`, `irq` and both DMA requests are low.
- R2: The writable bits read back at their offsets. Configuration at 0x00 keeps bits 15:8 and 6:4, and bits 2:0. Control at 0x04 keeps bits 15:14 and 8:0. Format at 0x10 keeps bits 13:12, 4 and 0. Divider at 0x30 keeps bits 11:8 and 3:0. Address bits 1:0 are ignored.
- R3: A bus write to 0x34 pushes the word into the transmit FIFO (32 deep), unless the FIFO is full. FIFO status (0x14) bits 13:8 give the transmit level. `tx_valid` equals configuration bit 0 AND control bit 1. Samples leave on `tx_data` in write order, one per `tx_valid && tx_ready` cycle.
- R4: `rx_ready` is high when configuration bit 0 and control bit 0 are set, the FIFO is not full, and loopback is off. Each accepted sample enters the receive FIFO, and FIFO status bits 5:0 give the receive level. A bus read of 0x34 returns the oldest sample and pops it. A read of 0x34 with the FIFO empty returns zero and pops nothing.
- R5: `dma_tx_req` is high exactly when configuration bit 0 is set, control bit 14 is set, and the transmit level is at or below the transmit threshold.
- R6: `dma_rx_req` is high exactly when configuration bit 0 is set, control bit 15 is set, and the receive level is at or above the receive threshold.
- R7: A transmit handshake with an empty FIFO sets FIFO status bit 16, which stays set. While the FIFO is empty, `tx_data` is zero when configuration bit 6 is clear. When bit 6 is set, `tx_data` is the last sample that left the FIFO.
- R8: A receive push offered while capture runs and the FIFO is full is dropped and sets FIFO status bit 17, which stays set. Writing 1 to bit 16 or bit 17 of FIFO status clears that bit. A new event in the same cycle wins over the clear.
- R9: `irq` is the OR of four terms, each gated by its control enable bit: transmit service (bit 3), receive service (bit 4), the underrun sticky bit (bit 5) and the overrun sticky bit (bit 6). Transmit service and receive service use the same conditions as R5 and R6, without the DMA enables.
- R10: With `SHARED_FLUSH`=0, control bit 7 empties the receive FIFO and control bit 8 empties the transmit FIFO. A flush bit reads 1 in the cycle after it is written and clears itself at the next edge, and that same edge empties the FIFO.
- R11: With `SHARED_FLUSH`=1, control bit 8 empties both FIFOs and control bit 7 has no effect on either FIFO.
- R12: Writing configuration with bit 3 set returns every register, both FIFOs, the sticky bits and the replay sample to their reset values at that edge. Bit 3 always reads 0.
- R13: With control bit 2 (loopback) set and capture running, each transmit handshake pushes the emitted `tx_data` into the receive FIFO, and `rx_valid` is ignored.
- R14: Configuration bits 1, 2, 4 and 5 drive `fsync_master`, `bclk_master`, `i2s_mode` and `int_codec`. Format bits 0 and 4 drive `fmt_msb` and `fmt_sysclk`. Divider bits 3:0 drive `play_div` and bits 11:8 drive `cap_div`. Serial status at 0x1C reads `eng_busy` in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Playback running |
| tx_ready | input | 1 | Engine takes a sample this cycle |
| tx_data | output | DATA_W | Transmit sample or fill value |
| rx_valid | input | 1 | Engine offers a capture sample |
| rx_ready | output | 1 | Receive FIFO accepts a sample |
| rx_data | input | DATA_W | Capture sample |
| dma_tx_req | output | 1 | Transmit DMA service request |
| dma_rx_req | output | 1 | Receive DMA service request |
| irq | output | 1 | Combined interrupt |
| eng_busy | input | 1 | Serial engine busy flag |
| port_en | output | 1 | Global enable |
| fsync_master | output | 1 | Frame sync generated locally |
| bclk_master | output | 1 | Bit clock generated locally |
| i2s_mode | output | 1 | I2S framing selected |
| int_codec | output | 1 | Internal codec selected |
| fmt_msb | output | 1 | MSB-justified format |
| fmt_sysclk | output | 1 | System clock output enable |
| play_div | output | 4 | Playback clock divider |
| cap_div | output | 4 | Capture clock divider |

## Verification
Read data and the FIFO data popped by a read are due in the access cycle itself. A write, push, pop, handshake or sticky event becomes visible after the single clock edge that ends the access. The one exception is a flush: it reads back as set for one cycle and empties the FIFO on the second edge. The bench drives every input just after a falling edge and samples outputs either 1 ns into the access cycle (bus reads) or at the falling edge after the edge of interest. It checks flush levels only after a further read has consumed the second edge. A second instance built with `SHARED_FLUSH`=1 receives the same stimulus, so the two flush modes are compared on identical FIFO contents.

// File: rtl/aud_pkg.sv
package aud_pkg;
  localparam int OFS_CFG   = 'h00;
  localparam int OFS_CTRL  = 'h04;
  localparam int OFS_FMT   = 'h10;
  localparam int OFS_FSTAT = 'h14;
  localparam int OFS_SSTAT = 'h1C;
  localparam int OFS_DIV   = 'h30;
  localparam int OFS_DATA  = 'h34;

  localparam int CFG_EN     = 0;
  localparam int CFG_FSM    = 1;
  localparam int CFG_BCM    = 2;
  localparam int CFG_SRST   = 3;
  localparam int CFG_I2S    = 4;
  localparam int CFG_INTC   = 5;
  localparam int CFG_REPLAY = 6;
  localparam int CFG_TXTHR_LSB = 8;
  localparam int CFG_RXTHR_LSB = 12;
  localparam int THR_W = 4;

  localparam int CTL_CAP    = 0;
  localparam int CTL_PLAY   = 1;
  localparam int CTL_LOOP   = 2;
  localparam int CTL_IE_TXS = 3;
  localparam int CTL_IE_RXS = 4;
  localparam int CTL_IE_TUR = 5;
  localparam int CTL_IE_ROR = 6;
  localparam int CTL_RFL    = 7;
  localparam int CTL_TFL    = 8;
  localparam int CTL_TXDMA  = 14;
  localparam int CTL_RXDMA  = 15;

  localparam int STAT_TXLVL_LSB = 8;
  localparam int STAT_TUR = 16;
  localparam int STAT_ROR = 17;
  localparam int SST_BUSY = 2;

  localparam logic [31:0] CFG_WMASK  = 32'h0000_FF77;
  localparam logic [31:0] CTRL_WMASK = 32'h0000_C1FF;
  localparam logic [31:0] FMT_WMASK  = 32'h0000_3011;
  localparam logic [31:0] DIV_WMASK  = 32'h0000_0F0F;
  localparam logic [31:0] FLUSH_BITS = 32'h0000_0180;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CFG, SEL_CTRL, SEL_FMT, SEL_FSTAT, SEL_SSTAT, SEL_DIV, SEL_DATA
  } reg_sel_e;
endpackage

// File: rtl/aud_sfifo.sv
module aud_sfifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end
endmodule

// File: rtl/aud_regs.sv
module aud_regs
  import aud_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int LVL_W      = 6,
  parameter int RX_THR_RST = 7,
  parameter int TX_THR_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [LVL_W-1:0]  tx_lvl,
  input  logic [LVL_W-1:0]  rx_lvl,
  input  logic [DATA_W-1:0] rx_head,
  input  logic              rx_empty,
  input  logic              eng_busy,
  input  logic              tur_evt,
  input  logic              ror_evt,
  output logic [31:0]       cfg_q,
  output logic [31:0]       ctrl_q,
  output logic [31:0]       fmt_q,
  output logic [31:0]       div_q,
  output logic              tur_st,
  output logic              ror_st,
  output logic              soft_rst,
  output logic              data_push,
  output logic              data_pop
);
  localparam logic [31:0] CFG_RST =
    (32'(RX_THR_RST) << CFG_RXTHR_LSB) | (32'(TX_THR_RST) << CFG_TXTHR_LSB);

  reg_sel_e          sel;
  logic [ADDR_W-1:0] wa;
  logic              wr, rd;
  logic [31:0]       stat;
  logic              unused_addr;

  assign wa          = {bus_addr[ADDR_W-1:2], 2'b00};
  assign unused_addr = ^bus_addr[1:0];
  assign wr          = bus_sel && bus_wr;
  assign rd          = bus_sel && !bus_wr;

  always_comb begin
    if      (wa == ADDR_W'(OFS_CFG))   sel = SEL_CFG;
    else if (wa == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
    else if (wa == ADDR_W'(OFS_FMT))   sel = SEL_FMT;
    else if (wa == ADDR_W'(OFS_FSTAT)) sel = SEL_FSTAT;
    else if (wa == ADDR_W'(OFS_SSTAT)) sel = SEL_SSTAT;
    else if (wa == ADDR_W'(OFS_DIV))   sel = SEL_DIV;
    else if (wa == ADDR_W'(OFS_DATA))  sel = SEL_DATA;
    else                               sel = SEL_NONE;
  end

  assign soft_rst  = wr && (sel == SEL_CFG) && bus_wdata[CFG_SRST];
  assign data_push = wr && (sel == SEL_DATA);
  assign data_pop  = rd && (sel == SEL_DATA) && !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      ctrl_q <= '0;
      fmt_q  <= '0;
      div_q  <= '0;
      tur_st <= 1'b0;
      ror_st <= 1'b0;
    end else if (soft_rst) begin
      cfg_q  <= CFG_RST;
      ctrl_q <= '0;
      fmt_q  <= '0;
      div_q  <= '0;
      tur_st <= 1'b0;
      ror_st <= 1'b0;
    end else begin
      if (wr && sel == SEL_CFG) cfg_q <= bus_wdata & CFG_WMASK;
      if (wr && sel == SEL_CTRL) ctrl_q <= bus_wdata & CTRL_WMASK;
      else                       ctrl_q <= ctrl_q & ~FLUSH_BITS;
      if (wr && sel == SEL_FMT) fmt_q <= bus_wdata & FMT_WMASK;
      if (wr && sel == SEL_DIV) div_q <= bus_wdata & DIV_WMASK;
      tur_st <= tur_evt || (tur_st && !(wr && sel == SEL_FSTAT && bus_wdata[STAT_TUR]));
      ror_st <= ror_evt || (ror_st && !(wr && sel == SEL_FSTAT && bus_wdata[STAT_ROR]));
    end
  end

  always_comb begin
    stat = '0;
    stat[STAT_TXLVL_LSB +: LVL_W] = tx_lvl;
    stat[0 +: LVL_W]              = rx_lvl;
    stat[STAT_TUR]                = tur_st;
    stat[STAT_ROR]                = ror_st;
  end

  always_comb begin
    unique case (sel)
      SEL_CFG:   bus_rdata = cfg_q;
      SEL_CTRL:  bus_rdata = ctrl_q;
      SEL_FMT:   bus_rdata = fmt_q;
      SEL_FSTAT: bus_rdata = stat;
      SEL_SSTAT: bus_rdata = 32'(eng_busy) << SST_BUSY;
      SEL_DIV:   bus_rdata = div_q;
      SEL_DATA:  bus_rdata = rx_empty ? 32'h0 : 32'(rx_head);
      default:   bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/aud_fifo_ctrl.sv
module aud_fifo_ctrl
  import aud_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int DEPTH        = 32,
  parameter int ADDR_W       = 8,
  parameter int RX_THR_RST   = 7,
  parameter int TX_THR_RST   = 8,
  parameter bit SHARED_FLUSH = 1'b0,
  localparam int LVL_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              dma_tx_req,
  output logic              dma_rx_req,
  output logic              irq,
  input  logic              eng_busy,
  output logic              port_en,
  output logic              fsync_master,
  output logic              bclk_master,
  output logic              i2s_mode,
  output logic              int_codec,
  output logic              fmt_msb,
  output logic              fmt_sysclk,
  output logic [3:0]        play_div,
  output logic [3:0]        cap_div
);
  logic [31:0]       cfg_q, ctrl_q, fmt_q, div_q;
  logic              tur_st, ror_st, soft_rst;
  logic              data_push, data_pop;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl, tx_thr, rx_thr;
  logic [DATA_W-1:0] tx_head, rx_head, last_q, rx_in_data;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              play_act, cap_act, loop_on, tx_fire, tx_pop;
  logic              rx_in_valid, rx_push, tur_evt, ror_evt;
  logic              tx_clr, rx_clr, tx_svc, rx_svc;
  logic              unused_regs;

  aud_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W),
    .RX_THR_RST(RX_THR_RST), .TX_THR_RST(TX_THR_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .rx_head(rx_head), .rx_empty(rx_empty),
    .eng_busy(eng_busy), .tur_evt(tur_evt), .ror_evt(ror_evt),
    .cfg_q(cfg_q), .ctrl_q(ctrl_q), .fmt_q(fmt_q), .div_q(div_q),
    .tur_st(tur_st), .ror_st(ror_st), .soft_rst(soft_rst),
    .data_push(data_push), .data_pop(data_pop)
  );

  assign port_en  = cfg_q[CFG_EN];
  assign play_act = port_en && ctrl_q[CTL_PLAY];
  assign cap_act  = port_en && ctrl_q[CTL_CAP];
  assign loop_on  = ctrl_q[CTL_LOOP];

  // Transmit side: the engine pulls; empty handshakes emit a fill value.
  assign tx_valid = play_act;
  assign tx_fire  = tx_valid && tx_ready;
  assign tx_pop   = tx_fire && !tx_empty;
  assign tur_evt  = tx_fire && tx_empty;
  assign tx_data  = !tx_empty ? tx_head : (cfg_q[CFG_REPLAY] ? last_q : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_q <= '0;
    else if (soft_rst) last_q <= '0;
    else if (tx_pop)   last_q <= tx_head;
  end

  // Receive side: loopback feeds emitted transmit samples back in.
  assign rx_in_valid = loop_on ? tx_fire : rx_valid;
  assign rx_in_data  = loop_on ? tx_data : rx_data;
  assign rx_push     = cap_act && rx_in_valid && !rx_full;
  assign ror_evt     = cap_act && rx_in_valid && rx_full;
  assign rx_ready    = cap_act && !rx_full && !loop_on;

  generate
    if (SHARED_FLUSH) begin : g_shared_flush
      assign tx_clr = soft_rst || ctrl_q[CTL_TFL];
      assign rx_clr = soft_rst || ctrl_q[CTL_TFL];
    end else begin : g_split_flush
      assign tx_clr = soft_rst || ctrl_q[CTL_TFL];
      assign rx_clr = soft_rst || ctrl_q[CTL_RFL];
    end
  endgenerate

  aud_sfifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(data_push), .din(DATA_W'(bus_wdata)), .pop(tx_pop),
    .dout(tx_head), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  aud_sfifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_push), .din(rx_in_data), .pop(data_pop),
    .dout(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  // Service thresholds
  assign tx_thr = LVL_W'(cfg_q[CFG_TXTHR_LSB +: THR_W]);
  assign rx_thr = LVL_W'(cfg_q[CFG_RXTHR_LSB +: THR_W]);
  assign tx_svc = port_en && (tx_lvl <= tx_thr);
  assign rx_svc = port_en && (rx_lvl >= rx_thr);

  assign dma_tx_req = tx_svc && ctrl_q[CTL_TXDMA];
  assign dma_rx_req = rx_svc && ctrl_q[CTL_RXDMA];
  assign irq = (tx_svc && ctrl_q[CTL_IE_TXS]) || (rx_svc && ctrl_q[CTL_IE_RXS]) ||
               (tur_st && ctrl_q[CTL_IE_TUR]) || (ror_st && ctrl_q[CTL_IE_ROR]);

  assign fsync_master = cfg_q[CFG_FSM];
  assign bclk_master  = cfg_q[CFG_BCM];
  assign i2s_mode     = cfg_q[CFG_I2S];
  assign int_codec    = cfg_q[CFG_INTC];
  assign fmt_msb      = fmt_q[0];
  assign fmt_sysclk   = fmt_q[4];
  assign play_div     = div_q[3:0];
  assign cap_div      = div_q[11:8];
  assign unused_regs  = ^{cfg_q, ctrl_q, fmt_q, div_q, tx_full};
endmodule

// File: rtl/aud_fifo_ctrl_chk.sv
module aud_fifo_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int LVL_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              dma_tx_req,
  input logic [31:0]       cfg_q,
  input logic [31:0]       ctrl_q,
  input logic [LVL_W-1:0]  tx_lvl,
  input logic [LVL_W-1:0]  rx_lvl,
  input logic              tur_st,
  input logic              ror_st,
  input logic              soft_rst
);
  AST_TX_LVL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= LVL_W'(DEPTH)); // R3

  AST_RX_READY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (rx_lvl < LVL_W'(DEPTH))); // R4

  AST_DMA_TX_THR: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> (cfg_q[0] && tx_lvl <= LVL_W'(cfg_q[11:8]))); // R5

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_lvl == '0 && !soft_rst) |=> tur_st); // R7

  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_lvl == '0 && !cfg_q[6]) |-> (tx_data == '0)); // R7

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ctrl_q[2] && cfg_q[0] && ctrl_q[0] && rx_lvl == LVL_W'(DEPTH) && !soft_rst)
      |=> ror_st); // R8

  AST_FLUSH_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[8] && !(bus_sel && bus_wr)) |=> !ctrl_q[8]); // R10

  AST_SOFTRST_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_lvl == '0 && rx_lvl == '0 && ctrl_q == '0 && !tur_st && !ror_st)); // R12
endmodule

bind aud_fifo_ctrl aud_fifo_ctrl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .dma_tx_req(dma_tx_req),
  .cfg_q(cfg_q), .ctrl_q(ctrl_q), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
  .tur_st(tur_st), .ror_st(ror_st), .soft_rst(soft_rst)
);

// File: tb/aud_fifo_ctrl_test.sv
`timescale 1ns/1ps
module aud_fifo_ctrl_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        tx_ready = 1'b0, rx_valid = 1'b0, eng_busy = 1'b0;
  logic [31:0] rx_data = '0;

  logic [31:0] rdata, s_rdata, tx_data, s_tx_data;
  logic tx_valid, rx_ready, dma_tx_req, dma_rx_req, irq, port_en;
  logic fsync_master, bclk_master, i2s_mode, int_codec, fmt_msb, fmt_sysclk;
  logic [3:0] play_div, cap_div;
  logic s_tx_valid, s_rx_ready, s_dtx, s_drx, s_irq, s_en, s_fs, s_bc, s_i2s, s_ic, s_fm, s_fsc;
  logic [3:0] s_pd, s_cd;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  aud_fifo_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .irq(irq), .eng_busy(eng_busy),
    .port_en(port_en), .fsync_master(fsync_master), .bclk_master(bclk_master),
    .i2s_mode(i2s_mode), .int_codec(int_codec), .fmt_msb(fmt_msb), .fmt_sysclk(fmt_sysclk),
    .play_div(play_div), .cap_div(cap_div)
  );

  aud_fifo_ctrl #(.SHARED_FLUSH(1'b1)) uut_shr (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(s_rdata), .tx_valid(s_tx_valid), .tx_ready(tx_ready),
    .tx_data(s_tx_data), .rx_valid(rx_valid), .rx_ready(s_rx_ready), .rx_data(rx_data),
    .dma_tx_req(s_dtx), .dma_rx_req(s_drx), .irq(s_irq), .eng_busy(eng_busy),
    .port_en(s_en), .fsync_master(s_fs), .bclk_master(s_bc), .i2s_mode(s_i2s),
    .int_codec(s_ic), .fmt_msb(s_fm), .fmt_sysclk(s_fsc), .play_div(s_pd), .cap_div(s_cd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d0 = rdata; d1 = s_rdata;
    tick();
    bus_sel = 1'b0;
  endtask

  task automatic tx_pull();
    tx_ready = 1'b1;
    tick();
    tx_ready = 1'b0;
  endtask

  task automatic rx_push(input logic [31:0] d);
    rx_valid = 1'b1; rx_data = d;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] a, b;
    rd(8'h00, a, b); chk("R1 cfg reset", a, 32'h0000_7800);
    rd(8'h04, a, b); chk("R1 ctrl reset", a, 32'h0);
    rd(8'h14, a, b); chk("R1 fifo status reset", a, 32'h0);
    chk("R1 outputs idle", {27'h0, tx_valid, rx_ready, irq, dma_tx_req, dma_rx_req}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] a, b;
    wr(8'h30, 32'hFFFF_FA05);
    rd(8'h31, a, b); chk("R2 divider readback", a, 32'h0000_0A05);
    chk("R14 divider pins", {24'h0, cap_div, play_div}, 32'h0000_00A5);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, a, b); chk("R2 format readback", a, 32'h0000_3011);
    chk("R14 format pins", {30'h0, fmt_sysclk, fmt_msb}, 32'h3);
    wr(8'h00, 32'h0000_7836);
    chk("R14 cfg pins", {28'h0, fsync_master, bclk_master, i2s_mode, int_codec}, 32'hF);
    eng_busy = 1'b1;
    rd(8'h1C, a, b); chk("R14 serial status busy", a, 32'h4);
    eng_busy = 1'b0;
    wr(8'h00, 32'h0000_7800);
  endtask

  task automatic t_tx();
    logic [31:0] a, b;
    wr(8'h00, 32'h0000_7801);
    wr(8'h04, 32'h0000_4002);
    chk("R5 tx dma at level 0", {31'h0, dma_tx_req}, 32'h1);
    chk("R3 tx_valid when playing", {31'h0, tx_valid}, 32'h1);
    for (int i = 0; i < 10; i++) wr(8'h34, 32'h100 + i);
    rd(8'h14, a, b); chk("R3 tx level 10", a, 32'h0000_0A00);
    chk("R5 tx dma above threshold", {31'h0, dma_tx_req}, 32'h0);
    for (int i = 0; i < 10; i++) begin
      chk("R3 tx order", tx_data, 32'h100 + i);
      tx_pull();
      if (i == 1) chk("R5 tx dma at threshold", {31'h0, dma_tx_req}, 32'h1);
    end
    rd(8'h14, a, b); chk("R3 tx drained", a, 32'h0);
  endtask

  task automatic t_under();
    logic [31:0] a, b;
    chk("R7 zero fill when empty", tx_data, 32'h0);
    tx_pull();
    rd(8'h14, a, b); chk("R7 underrun sticky", a, 32'h0001_0000);
    wr(8'h04, 32'h0000_4022);
    chk("R9 irq on underrun", {31'h0, irq}, 32'h1);
    wr(8'h00, 32'h0000_7841);
    chk("R7 replay last sample", tx_data, 32'h109);
    wr(8'h14, 32'h0001_0000);
    rd(8'h14, a, b); chk("R8 underrun cleared by write-one", a, 32'h0);
    chk("R9 irq drops after clear", {31'h0, irq}, 32'h0);
    wr(8'h00, 32'h0000_7801);
  endtask

  task automatic t_rx();
    logic [31:0] a, b;
    wr(8'h04, 32'h0000_8001);
    chk("R4 rx_ready when capturing", {31'h0, rx_ready}, 32'h1);
    chk("R6 rx dma below threshold", {31'h0, dma_rx_req}, 32'h0);
    for (int i = 0; i < 7; i++) rx_push(32'h200 + i);
    rd(8'h14, a, b); chk("R4 rx level 7", a, 32'h0000_0007);
    chk("R6 rx dma at threshold", {31'h0, dma_rx_req}, 32'h1);
    rd(8'h34, a, b); chk("R4 rx first sample", a, 32'h200);
    chk("R6 rx dma below after pop", {31'h0, dma_rx_req}, 32'h0);
    for (int i = 7; i < 33; i++) rx_push(32'h200 + i);
    chk("R4 rx_ready low when full", {31'h0, rx_ready}, 32'h0);
    rx_push(32'h2FF);
    rd(8'h14, a, b); chk("R8 overrun sticky, level kept", a, 32'h0002_0020);
    for (int i = 0; i < 32; i++) begin
      rd(8'h34, a, b); chk("R8 rx order, dropped sample absent", a, 32'h201 + i);
    end
    rd(8'h34, a, b); chk("R4 empty read returns zero", a, 32'h0);
    rd(8'h14, a, b); chk("R4 empty read pops nothing", a, 32'h0002_0000);
    wr(8'h14, 32'h0002_0000);
    rd(8'h14, a, b); chk("R8 overrun cleared", a, 32'h0);
  endtask

  task automatic t_loop();
    logic [31:0] a, b;
    wr(8'h04, 32'h0000_0007);
    for (int i = 0; i < 3; i++) wr(8'h34, 32'h300 + i);
    chk("R13 rx_ready low in loopback", {31'h0, rx_ready}, 32'h0);
    rx_valid = 1'b1; rx_data = 32'hDEAD;
    for (int i = 0; i < 3; i++) tx_pull();
    rx_valid = 1'b0;
    rd(8'h14, a, b); chk("R13 loopback level", a, 32'h0000_0003);
    for (int i = 0; i < 3; i++) begin
      rd(8'h34, a, b); chk("R13 loopback data", a, 32'h300 + i);
    end
    wr(8'h04, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] a, b;
    wr(8'h04, 32'h0000_0001);
    for (int i = 0; i < 4; i++) wr(8'h34, 32'h400 + i);
    for (int i = 0; i < 3; i++) rx_push(32'h500 + i);
    rd(8'h14, a, b);
    chk("R10 levels before flush", a, 32'h0000_0403);
    chk("R11 levels before flush", b, 32'h0000_0403);
    wr(8'h04, 32'h0000_0081);
    rd(8'h04, a, b); chk("R10 rx flush bit visible one cycle", a, 32'h0000_0081);
    rd(8'h04, a, b); chk("R10 rx flush bit self-clears", a, 32'h0000_0001);
    rd(8'h14, a, b);
    chk("R10 rx flush empties only rx", a, 32'h0000_0400);
    chk("R11 rx flush bit has no effect when shared", b, 32'h0000_0403);
    wr(8'h04, 32'h0000_0101);
    rd(8'h04, a, b); chk("R10 tx flush bit visible", a, 32'h0000_0101);
    rd(8'h14, a, b);
    chk("R10 tx flush empties tx", a, 32'h0);
    chk("R11 shared flush empties both", b, 32'h0);
  endtask

  task automatic t_srst();
    logic [31:0] a, b;
    wr(8'h04, 32'h0000_4002);
    wr(8'h34, 32'h777);
    wr(8'h34, 32'h778);
    wr(8'h00, 32'h0000_0049);
    rd(8'h00, a, b); chk("R12 cfg default after soft reset", a, 32'h0000_7800);
    rd(8'h04, a, b); chk("R12 ctrl cleared", a, 32'h0);
    rd(8'h14, a, b); chk("R12 fifos emptied", a, 32'h0);
    rd(8'h30, a, b); chk("R12 divider cleared", a, 32'h0);
    chk("R12 playback stopped", {31'h0, tx_valid}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_tx();
    t_under();
    t_rx();
    t_loop();
    t_flush();
    t_srst();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule